// File: doc/BRIEF.md
# Cell-Gated Transmit Byte Buffer

This block sits between a DMA engine that writes outgoing packet data as 32-bit words and a line-side consumer that takes one byte at a time. The data lands in a ring of three fixed 64-byte cells. A cell is claimed whole and handed back whole: it becomes readable once filled, or once it holds the final word of a packet, and returns to the free pool when its last byte has gone out.

The line side does not start on a packet as soon as data appears. It waits until a programmable number of cells is full or until the complete packet is held, whichever comes first. After that it hands out one byte per pacing tick. The tick rate is chosen by a speed-mode input so that one cell drains in 5.12 µs in fast mode and in 51.2 µs in slow mode.

If a tick arrives while the next cell of a running packet has not been filled, that is an underrun. The block raises a sticky flag, abandons the packet and throws away the rest of it as it arrives. The packet that follows is sent normally.

Top module: `cell_txfifo`

## Requirements
- R1: After reset, rd_valid_o, underrun_o and tx_active_o are low and wr_ready_o is high.
- R2: Bytes leave in write order, lane 0 (bits 7:0) of each word first. On a word with wr_eop_i high, wr_be_i gives the valid lanes counted from lane 0 (a value of 0 counts as all four). On other words all four lanes are valid.
- R3: The buffer holds three cells of 64 bytes. wr_ready_o goes low when the next cell in the ring is still holding unsent data. It returns high only after the last byte of that cell has been handed out.
- R4: A packet starts once the effective threshold number of consecutive cells is full. The effective threshold is thr_i, with 0 read as 1 and any value above 3 read as 3.
- R5: A packet also starts once all of it is buffered, even when fewer cells than the threshold are full. So a packet no longer than threshold × 64 bytes never underruns, however slowly it was written.
- R6: With rd_ready_i held high, consecutive bytes of a packet are handed out every FAST_DIV = 20 cycles when fast_i = 1, and every SLOW_DIV = 200 cycles when fast_i = 0. At 250 MHz that is 80 ns and 800 ns per byte.
- R7: rd_last_o is high with the final byte of each completed packet and low for every other byte.
- R8: When a pacing tick finds the next cell of a running packet not yet full, underrun_o rises and stays high until reset. No further byte of that packet is handed out, and no rd_last_o is given for it.
- R9: The words of an aborted packet written after the underrun are accepted and discarded up to its end-of-packet word. The next packet is then sent complete.
- R10: tx_active_o is high from the start of a packet until its last byte is handed out, and low while the block waits for its start condition.
- R11: While rd_valid_o is high and rd_ready_i is low, rd_valid_o, rd_data_o and rd_last_o hold their values, and no underrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write word valid |
| wr_ready_o | output | 1 | Write word accepted on this edge when valid |
| wr_data_i | input | 32 | Write word, lane 0 in bits 7:0 |
| wr_be_i | input | 4 | Valid lanes of the end-of-packet word |
| wr_eop_i | input | 1 | Marks the final word of a packet |
| thr_i | input | 3 | Start threshold in full cells |
| fast_i | input | 1 | 1: fast pacing, 0: slow pacing |
| rd_valid_o | output | 1 | Output byte valid |
| rd_ready_i | input | 1 | Line side takes the byte |
| rd_data_o | output | 8 | Output byte |
| rd_last_o | output | 1 | Final byte of a packet |
| underrun_o | output | 1 | Sticky underrun flag |
| tx_active_o | output | 1 | A packet is being sent |

## Verification
The hardest case to reach from the ports is an underrun in the middle of a packet that is then followed by a clean packet. The bench writes exactly one cell of a long packet with the threshold at one. It then holds the write side idle for longer than a cell takes to drain, so the next tick finds an unfilled cell. Only after that does it write the rest of the packet and a second, short packet. It expects exactly the first 64 bytes, with no last strobe, followed by the whole second packet.

// File: rtl/cell_txfifo_pkg.sv
package cell_txfifo_pkg;
    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_SEND = 2'd1,
        RS_DROP = 2'd2
    } rd_state_e;
endpackage

// File: rtl/cell_txfifo_pacer.sv
module cell_txfifo_pacer #(
    parameter int FAST_DIV = 20,
    parameter int SLOW_DIV = 200
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fast_i,
    output logic tick_o
);
    localparam int MAXDIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int CW     = $clog2(MAXDIV);

    logic [CW-1:0] cnt_d, cnt_q, lim;

    always_comb begin
        lim    = fast_i ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1);
        tick_o = (cnt_q >= lim);
        cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cell_txfifo_mem.sv
module cell_txfifo_mem #(
    parameter int WORDS  = 48,
    parameter int ADDR_W = 6
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [31:0]       wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [31:0]       rdata_o
);
    logic [31:0] mem_q [WORDS];

    always_ff @(posedge clk_i) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cell_txfifo.sv
module cell_txfifo #(
    parameter int CELL_BYTES = 64,
    parameter int NUM_CELLS  = 3,
    parameter int FAST_DIV   = 20,
    parameter int SLOW_DIV   = 200,
    parameter int THR_W      = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_valid_i,
    output logic             wr_ready_o,
    input  logic [31:0]      wr_data_i,
    input  logic [3:0]       wr_be_i,
    input  logic             wr_eop_i,
    input  logic [THR_W-1:0] thr_i,
    input  logic             fast_i,
    output logic             rd_valid_o,
    input  logic             rd_ready_i,
    output logic [7:0]       rd_data_o,
    output logic             rd_last_o,
    output logic             underrun_o,
    output logic             tx_active_o
);
    import cell_txfifo_pkg::*;

    localparam int CELL_WORDS = CELL_BYTES / 4;
    localparam int MEM_WORDS  = NUM_CELLS * CELL_WORDS;
    localparam int IDX_W      = $clog2(NUM_CELLS);
    localparam int WORD_W     = $clog2(CELL_WORDS);
    localparam int BYTE_W     = $clog2(CELL_BYTES);
    localparam int CNT_W      = BYTE_W + 1;
    localparam int ADDR_W     = $clog2(MEM_WORDS);

    typedef struct packed {
        rd_state_e                       st;
        logic [NUM_CELLS-1:0]            full;
        logic [NUM_CELLS-1:0]            eop;
        logic [NUM_CELLS-1:0][CNT_W-1:0] cnt;
        logic [IDX_W-1:0]                wcell;
        logic [WORD_W-1:0]               wword;
        logic [IDX_W-1:0]                rcell;
        logic [BYTE_W-1:0]               rbyte;
        logic                            ovld;
        logic [7:0]                      odata;
        logic                            olast;
        logic                            urun;
    } state_t;

    state_t s_d, s_q;

    logic              tick;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr;
    logic [31:0]       mem_rdata;
    logic [7:0]        cur_byte;

    function automatic logic [IDX_W-1:0] next_cell(input logic [IDX_W-1:0] c);
        return (c == IDX_W'(NUM_CELLS - 1)) ? '0 : c + 1'b1;
    endfunction

    cell_txfifo_pacer #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_pacer (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .fast_i(fast_i),
        .tick_o(tick)
    );

    cell_txfifo_mem #(.WORDS(MEM_WORDS), .ADDR_W(ADDR_W)) u_mem (
        .clk_i  (clk_i),
        .we_i   (mem_we),
        .waddr_i(mem_waddr),
        .wdata_i(wr_data_i),
        .raddr_i(mem_raddr),
        .rdata_o(mem_rdata)
    );

    always_comb begin
        logic [IDX_W-1:0] c;
        logic [3:0]       be_eff;
        logic             stop;
        logic             pkt_done;
        logic             cell_end;
        int               chain;
        int               thr_eff;

        s_d = s_q;

        // effective threshold, clamped to [1, NUM_CELLS]
        if (thr_i == '0)                    thr_eff = 1;
        else if (int'(thr_i) > NUM_CELLS)   thr_eff = NUM_CELLS;
        else                                thr_eff = int'(thr_i);

        // write side: fill the current cell, close it on the last word or on eop
        wr_ready_o = !s_q.full[s_q.wcell];
        mem_we     = wr_valid_i && wr_ready_o;
        mem_waddr  = ADDR_W'(s_q.wcell) * ADDR_W'(CELL_WORDS) + ADDR_W'(s_q.wword);
        be_eff     = (wr_be_i == 4'd0) ? 4'hF : wr_be_i;
        if (mem_we) begin
            if (wr_eop_i || s_q.wword == WORD_W'(CELL_WORDS - 1)) begin
                s_d.full[s_q.wcell] = 1'b1;
                s_d.eop[s_q.wcell]  = wr_eop_i;
                s_d.cnt[s_q.wcell]  = wr_eop_i
                    ? CNT_W'({s_q.wword, 2'b00}) + CNT_W'($countones(be_eff))
                    : CNT_W'(CELL_BYTES);
                s_d.wcell = next_cell(s_q.wcell);
                s_d.wword = '0;
            end else begin
                s_d.wword = s_q.wword + 1'b1;
            end
        end

        // start condition: consecutive full cells from the read cell
        chain    = 0;
        stop     = 1'b0;
        pkt_done = 1'b0;
        c        = s_q.rcell;
        for (int k = 0; k < NUM_CELLS; k++) begin
            if (!stop && s_q.full[c]) begin
                chain = chain + 1;
                if (s_q.eop[c]) pkt_done = 1'b1;
            end else begin
                stop = 1'b1;
            end
            c = next_cell(c);
        end

        // read side
        mem_raddr = ADDR_W'(s_q.rcell) * ADDR_W'(CELL_WORDS) + ADDR_W'(s_q.rbyte >> 2);
        cur_byte  = 8'(mem_rdata >> {s_q.rbyte[1:0], 3'b000});
        cell_end  = (CNT_W'(s_q.rbyte) == s_q.cnt[s_q.rcell] - CNT_W'(1));

        if (s_q.ovld && rd_ready_i) begin
            s_d.ovld  = 1'b0;
            s_d.olast = 1'b0;
        end

        unique case (s_q.st)
            RS_IDLE: begin
                if (chain >= thr_eff || pkt_done) s_d.st = RS_SEND;
            end
            RS_SEND: begin
                if (tick && (!s_q.ovld || rd_ready_i)) begin
                    if (s_q.full[s_q.rcell]) begin
                        s_d.ovld  = 1'b1;
                        s_d.odata = cur_byte;
                        s_d.olast = cell_end && s_q.eop[s_q.rcell];
                        if (cell_end) begin
                            s_d.full[s_q.rcell] = 1'b0;
                            s_d.rcell = next_cell(s_q.rcell);
                            s_d.rbyte = '0;
                            if (s_q.eop[s_q.rcell]) s_d.st = RS_IDLE;
                        end else begin
                            s_d.rbyte = s_q.rbyte + 1'b1;
                        end
                    end else begin
                        s_d.urun = 1'b1;
                        s_d.st   = RS_DROP;
                    end
                end
            end
            RS_DROP: begin
                if (s_q.full[s_q.rcell]) begin
                    s_d.full[s_q.rcell] = 1'b0;
                    s_d.rcell = next_cell(s_q.rcell);
                    if (s_q.eop[s_q.rcell]) s_d.st = RS_IDLE;
                end
            end
            default: s_d.st = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign rd_valid_o  = s_q.ovld;
    assign rd_data_o   = s_q.odata;
    assign rd_last_o   = s_q.olast;
    assign underrun_o  = s_q.urun;
    assign tx_active_o = (s_q.st == RS_SEND);
endmodule

// File: rtl/cell_txfifo_chk.sv
module cell_txfifo_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       rd_valid_o,
    input logic       rd_ready_i,
    input logic [7:0] rd_data_o,
    input logic       rd_last_o,
    input logic       underrun_o,
    input logic       tx_active_o
);
    // R8: underrun flag never falls outside reset
    a_r8_underrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        underrun_o |=> underrun_o);

    // R8: raising underrun ends the packet in progress
    a_r8_abort_ends_send: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(underrun_o) |-> !tx_active_o);

    // R7: last strobe only accompanies a valid byte
    a_r7_last_with_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_last_o |-> rd_valid_o);

    // R11: a stalled byte is held unchanged
    a_r11_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o) && $stable(rd_last_o)));

    // R10: a new byte only appears after the packet has started
    a_r10_byte_needs_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rd_valid_o) |-> $past(tx_active_o));
endmodule

bind cell_txfifo cell_txfifo_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_valid_o (rd_valid_o),
    .rd_ready_i (rd_ready_i),
    .rd_data_o  (rd_data_o),
    .rd_last_o  (rd_last_o),
    .underrun_o (underrun_o),
    .tx_active_o(tx_active_o)
);

// File: tb/cell_txfifo_bench.sv
module cell_txfifo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic        wr_eop = 1'b0;
    logic [2:0]  thr = 3'd1;
    logic        fast = 1'b1;
    logic        rd_valid;
    logic        rd_ready = 1'b1;
    logic [7:0]  rd_data;
    logic        rd_last;
    logic        underrun;
    logic        tx_active;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 0;

    logic [7:0] got_data[$];
    logic       got_last[$];
    int         got_cyc[$];
    logic [7:0] exp_data[$];
    logic       exp_last[$];

    cell_txfifo u_cell_txfifo (
        .clk_i(clk), .rst_ni(rst_n),
        .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_data_i(wr_data),
        .wr_be_i(wr_be), .wr_eop_i(wr_eop), .thr_i(thr), .fast_i(fast),
        .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_data_o(rd_data),
        .rd_last_o(rd_last), .underrun_o(underrun), .tx_active_o(tx_active)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && rd_valid && rd_ready) begin
            got_data.push_back(rd_data);
            got_last.push_back(rd_last);
            got_cyc.push_back(cyc);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] t, input logic f);
        @(negedge clk);
        rst_n = 1'b0; wr_valid = 1'b0; wr_eop = 1'b0; rd_ready = 1'b1;
        thr = t; fast = f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        got_data.delete(); got_last.delete(); got_cyc.delete();
        exp_data.delete(); exp_last.delete();
        @(negedge clk);
    endtask

    task automatic put_word(input logic [31:0] d, input logic [3:0] be, input logic eop);
        wr_valid = 1'b1; wr_data = d; wr_be = be; wr_eop = eop;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0; wr_eop = 1'b0;
    endtask

    // write words [w0, w1) of a packet of len bytes whose byte i is seed+i
    task automatic send_words(input int seed, input int len, input int w0, input int w1, input int gap);
        int nw = (len + 3) / 4;
        for (int w = w0; w < w1; w++) begin
            logic [31:0] d;
            logic [3:0]  be;
            int rem = len - 4 * w;
            for (int k = 0; k < 4; k++) d[8*k +: 8] = 8'(seed + 4 * w + k);
            be = (rem >= 4) ? 4'hF : 4'((1 << rem) - 1);
            put_word(d, be, (w == nw - 1));
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic expect_bytes(input int seed, input int n, input bit with_last);
        for (int i = 0; i < n; i++) begin
            exp_data.push_back(8'(seed + i));
            exp_last.push_back(with_last && (i == n - 1));
        end
    endtask

    task automatic compare_stream(input string req, input int limit);
        int n = 0;
        int bad = 0;
        int badl = 0;
        while (got_data.size() < exp_data.size() && n < limit) begin
            @(negedge clk); n++;
        end
        repeat (20) @(negedge clk);
        check(got_data.size() == exp_data.size(), req, "byte count", got_data.size(), exp_data.size());
        for (int i = 0; i < exp_data.size() && i < got_data.size(); i++) begin
            if (got_data[i] != exp_data[i]) begin
                if (bad == 0) check(0, req, $sformatf("byte %0d", i), got_data[i], exp_data[i]);
                bad++;
            end
            if (got_last[i] != exp_last[i]) begin
                if (badl == 0) check(0, "R7", $sformatf("last at byte %0d", i), got_last[i], exp_last[i]);
                badl++;
            end
        end
        check(bad == 0, req, "data mismatches", bad, 0);
        check(badl == 0, "R7", "last strobe mismatches", badl, 0);
    endtask

    task automatic check_spacing(input string req, input int first, input int last_i, input int gap);
        int bad = 0;
        int seen = 0;
        for (int i = first + 1; i <= last_i && i < got_cyc.size(); i++) begin
            if (got_cyc[i] - got_cyc[i-1] != gap) begin
                bad++; seen = got_cyc[i] - got_cyc[i-1];
            end
        end
        check(bad == 0, req, "byte spacing", (bad == 0) ? gap : seen, gap);
    endtask

    task automatic t_reset;
        do_reset(3'd1, 1'b1);
        check(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
        check(wr_ready == 1'b1, "R1", "wr_ready after reset", wr_ready, 1);
        check(underrun == 1'b0, "R1", "underrun after reset", underrun, 0);
        check(tx_active == 1'b0, "R1", "tx_active after reset", tx_active, 0);
    endtask

    // R5/R2: slow writer, packet fits within threshold, starts only when complete
    task automatic t_whole_packet;
        int early = 0;
        do_reset(3'd2, 1'b1);
        for (int w = 0; w < 26; w++) begin
            send_words(8'h10, 102, w, w + 1, 30);
            if (w < 25 && tx_active) early++;
        end
        check(early == 0, "R5", "started before packet complete", early, 0);
        expect_bytes(8'h10, 102, 1);
        compare_stream("R2", 5000);
        check(underrun == 1'b0, "R5", "underrun on short packet", underrun, 0);
        check(tx_active == 1'b0, "R10", "tx_active after packet", tx_active, 0);
    endtask

    // R4/R3/R6: threshold 1 starts on first cell; writer stalls on a busy cell
    task automatic t_thr_one;
        do_reset(3'd1, 1'b1);
        send_words(8'h40, 200, 0, 16, 0);
        repeat (100) @(negedge clk);
        check(tx_active == 1'b1, "R4", "start after one cell at thr 1", tx_active, 1);
        send_words(8'h40, 200, 16, 48, 0);
        check(wr_ready == 1'b0, "R3", "write stalls with all cells busy", wr_ready, 0);
        send_words(8'h40, 200, 48, 50, 0);
        expect_bytes(8'h40, 200, 1);
        compare_stream("R3", 10000);
        check_spacing("R6", 0, 199, 20);
        check(underrun == 1'b0, "R4", "no underrun with fast writer", underrun, 0);
    endtask

    // R4: threshold 0 behaves as 1
    task automatic t_thr_zero;
        do_reset(3'd0, 1'b1);
        send_words(8'h80, 130, 0, 16, 0);
        repeat (50) @(negedge clk);
        check(tx_active == 1'b1, "R4", "start after one cell at thr 0", tx_active, 1);
        send_words(8'h80, 130, 16, 33, 0);
        expect_bytes(8'h80, 130, 1);
        compare_stream("R4", 6000);
    endtask

    // R4: threshold 7 clamps to 3
    task automatic t_thr_clamp;
        do_reset(3'd7, 1'b1);
        send_words(8'h05, 200, 0, 32, 0);
        repeat (300) @(negedge clk);
        check(tx_active == 1'b0, "R4", "no start with two cells at thr 7", tx_active, 0);
        send_words(8'h05, 200, 32, 48, 0);
        repeat (5) @(negedge clk);
        check(tx_active == 1'b1, "R4", "start with three cells at thr 7", tx_active, 1);
        send_words(8'h05, 200, 48, 50, 0);
        expect_bytes(8'h05, 200, 1);
        compare_stream("R4", 10000);
    endtask

    // R6: slow pacing
    task automatic t_slow;
        do_reset(3'd1, 1'b0);
        send_words(8'hC0, 8, 0, 2, 0);
        expect_bytes(8'hC0, 8, 1);
        compare_stream("R6", 4000);
        check_spacing("R6", 0, 7, 200);
    endtask

    // R8/R9: cell not refilled in time, then a clean packet
    task automatic t_underrun;
        do_reset(3'd1, 1'b1);
        send_words(8'h20, 160, 0, 16, 0);
        repeat (1500) @(negedge clk);
        check(underrun == 1'b1, "R8", "underrun raised", underrun, 1);
        check(tx_active == 1'b0, "R8", "packet aborted", tx_active, 0);
        send_words(8'h20, 160, 16, 40, 0);
        send_words(8'hA0, 40, 0, 10, 0);
        expect_bytes(8'h20, 64, 0);
        expect_bytes(8'hA0, 40, 1);
        compare_stream("R9", 3000);
        check(underrun == 1'b1, "R8", "underrun stays set", underrun, 1);
    endtask

    // R11: output held while the line side stalls
    task automatic t_hold;
        logic [7:0] first;
        int n = 0;
        do_reset(3'd1, 1'b1);
        rd_ready = 1'b0;
        send_words(8'h33, 64, 0, 16, 0);
        while (!rd_valid && n < 500) begin @(negedge clk); n++; end
        first = rd_data;
        repeat (100) @(negedge clk);
        check(rd_valid == 1'b1, "R11", "valid held under stall", rd_valid, 1);
        check(rd_data == first, "R11", "data held under stall", rd_data, first);
        check(underrun == 1'b0, "R11", "no underrun under stall", underrun, 0);
        rd_ready = 1'b1;
        expect_bytes(8'h33, 64, 1);
        compare_stream("R11", 3000);
    endtask

    initial begin
        t_reset();
        t_whole_packet();
        t_thr_one();
        t_thr_zero();
        t_thr_clamp();
        t_slow();
        t_underrun();
        t_hold();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule